// File: doc/BRIEF.md
# Masked Symbol Error Checker

This block compares a stream of received 10-bit symbols with a reference stream and adds up the bit positions that disagree. The reference is either a small loadable pattern memory or a locally generated PRBS7 sequence. Before any errors are counted, the checker must align. It has to see a run of four consecutive symbols that match a training reference. That reference is either a fixed alternating symbol or the first four words (40 bits) of the pattern memory, replayed in order.

After lock, each valid symbol adds the number of mismatching bits to a saturating counter. A two-bit mask selector limits counting to all bits, odd bits only, even bits only, or no bits. A synchronous clear empties the counter and drops lock. Changing either configuration field forces a new training phase, and the count is kept. The block sits behind a serial receiver during link bring-up and bit-error-rate testing.

Top module: `sym_err_checker`

## Requirements
- R1: After reset or a one-cycle `clr` pulse, `err_count` is 0 and `locked` is 0 from the next clock edge on.
- R2: With `src_sel[0]`=0 the training reference is the fixed symbol 0101010101 (bit 0 = 1, value 0x155). `locked` rises on the edge that samples the fourth consecutive matching valid symbol. A mismatching valid symbol restarts the run, and cycles with `sym_valid`=0 neither advance nor break it.
- R3: With `src_sel[0]`=1 the training reference is pattern words 0,1,2,3 in that order. A mismatch restarts at word 0, so lock needs words 0..3 received in sequence.
- R4: While `locked` is 0, `err_count` does not change, whatever symbols arrive.
- R5: With `mask_sel`=00, each valid locked symbol adds the number of bit positions 0..9 where it differs from the expected symbol.
- R6: With `mask_sel`=01, only mismatches on bit positions 1,3,5,7,9 are added.
- R7: With `mask_sel`=10, only mismatches on bit positions 0,2,4,6,8 are added.
- R8: With `mask_sel`=11, nothing is added.
- R9: With `src_sel[1]`=0, the expected symbol after lock starts at pattern word 0. It steps one word per valid symbol, wrapping after word DEPTH-1 when `src_sel`=00 and after word 3 when `src_sel`=01. A word written through `pb_we`/`pb_addr`/`pb_wdata` is used from the next cycle.
- R10: With `src_sel[1]`=1, the first valid symbol after lock seeds the generator and adds nothing. Bit 0 of each symbol is earliest in time. Each following bit is b[n] = b[n-7] XOR b[n-6], continued across symbols.
- R11: `err_count` is 16 bits, never decreases except on clear, and holds at 0xFFFF instead of wrapping.
- R12: A change of `mask_sel` or `src_sel` drops `locked` on the next edge, restarts training and leaves `err_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of count, lock and generator |
| sym_valid | input | 1 | Received symbol strobe |
| sym_data | input | 10 | Received symbol, bit 0 earliest |
| mask_sel | input | 2 | 00 all, 01 odd, 10 even, 11 none |
| src_sel | input | 2 | bit 1: PRBS reference; bit 0: train on first 40 buffer bits |
| pb_we | input | 1 | Pattern memory write enable |
| pb_addr | input | 3 | Pattern memory word address |
| pb_wdata | input | 10 | Pattern memory write data |
| err_count | output | 16 | Saturating error count |
| locked | output | 1 | Training complete, counting active |

## Verification
Both `locked` and `err_count` are registers. Each reflects a symbol or a configuration change on the same rising edge that samples it, so a result is due one edge after the stimulus. The bench drives on falling edges and reads the outputs at the next falling edge, after that single edge. Expected counts come from an arithmetic model: a masked popcount per symbol and a bit-level PRBS recurrence. The model is updated symbol by symbol and compared after each symbol.

// File: rtl/sec_pkg.sv
package sec_pkg;
  typedef enum logic [1:0] {
    ST_TRAIN = 2'd0,
    ST_SEED  = 2'd1,
    ST_RUN   = 2'd2
  } chk_state_t;

  localparam logic [1:0] MSK_ALL  = 2'b00;
  localparam logic [1:0] MSK_ODD  = 2'b01;
  localparam logic [1:0] MSK_EVEN = 2'b10;
endpackage

// File: rtl/sec_pattern_buf.sv
module sec_pattern_buf #(
  parameter int SYM_W = 10,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [SYM_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [SYM_W-1:0] rdata
);
  logic [SYM_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sec_prbs7.sv
module sec_prbs7 #(
  parameter int SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SYM_W-1:0] seed,
  input  logic             adv,
  output logic [SYM_W-1:0] exp_sym
);
  logic [6:0] st;
  logic [6:0] walk;
  logic [6:0] seed_st;
  logic       nb;

  // Unroll SYM_W serial steps: newest bit enters at position 0.
  always_comb begin
    walk    = st;
    nb      = 1'b0;
    exp_sym = '0;
    for (int i = 0; i < SYM_W; i++) begin
      nb         = walk[6] ^ walk[5];
      exp_sym[i] = nb;
      walk       = {walk[5:0], nb};
    end
  end

  // Last seven received bits, newest at position 0.
  always_comb begin
    for (int k = 0; k < 7; k++) seed_st[k] = seed[SYM_W-1-k];
  end

  always_ff @(posedge clk) begin
    if (rst)       st <= 7'h7F;
    else if (load) st <= seed_st;
    else if (adv)  st <= walk;
  end
endmodule

// File: rtl/sec_mask_count.sv
module sec_mask_count
  import sec_pkg::*;
#(
  parameter int SYM_W = 10,
  localparam int CW = $clog2(SYM_W + 1)
) (
  input  logic [SYM_W-1:0] rx,
  input  logic [SYM_W-1:0] ref_sym,
  input  logic [1:0]       mask_sel,
  output logic [CW-1:0]    nerr
);
  logic [SYM_W-1:0] keep;
  logic [SYM_W-1:0] miss;

  for (genvar i = 0; i < SYM_W; i++) begin : g_bit
    localparam bit IS_ODD = (i % 2) == 1;
    assign keep[i] = (mask_sel == MSK_ALL) ||
                     (IS_ODD  && mask_sel == MSK_ODD) ||
                     (!IS_ODD && mask_sel == MSK_EVEN);
  end

  assign miss = (rx ^ ref_sym) & keep;

  always_comb begin
    nerr = '0;
    for (int i = 0; i < SYM_W; i++) nerr = nerr + CW'(miss[i]);
  end
endmodule

// File: rtl/sym_err_checker.sv
module sym_err_checker
  import sec_pkg::*;
#(
  parameter int SYM_W      = 10,
  parameter int DEPTH      = 8,
  parameter int CNT_W      = 16,
  parameter int TRAIN_SYMS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int TW = $clog2(TRAIN_SYMS),
  localparam int CW = $clog2(SYM_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym_data,
  input  logic [1:0]       mask_sel,
  input  logic [1:0]       src_sel,
  input  logic             pb_we,
  input  logic [AW-1:0]    pb_addr,
  input  logic [SYM_W-1:0] pb_wdata,
  output logic [CNT_W-1:0] err_count,
  output logic             locked
);
  function automatic logic [SYM_W-1:0] alt_pattern();
    logic [SYM_W-1:0] r;
    for (int i = 0; i < SYM_W; i++) r[i] = ((i % 2) == 0);
    return r;
  endfunction

  localparam logic [SYM_W-1:0] DEF_TRAIN = alt_pattern();

  chk_state_t       st;
  logic [TW-1:0]    mcnt;
  logic [AW-1:0]    rptr;
  logic [1:0]       mask_q;
  logic [1:0]       src_q;
  logic             cfg_chg;
  logic [AW-1:0]    rd_addr;
  logic [SYM_W-1:0] buf_word;
  logic [SYM_W-1:0] prbs_word;
  logic [SYM_W-1:0] train_ref;
  logic [SYM_W-1:0] run_ref;
  logic [AW-1:0]    rptr_last;
  logic [CW-1:0]    nerr;
  logic [CNT_W:0]   sum;
  logic             go;
  logic             seed_ld;
  logic             prbs_adv;

  assign cfg_chg   = (mask_sel != mask_q) || (src_sel != src_q);
  assign go        = sym_valid && !cfg_chg;
  assign rd_addr   = (st == ST_TRAIN) ? AW'(mcnt) : rptr;
  assign train_ref = src_sel[0] ? buf_word : DEF_TRAIN;
  assign run_ref   = src_sel[1] ? prbs_word : buf_word;
  assign rptr_last = src_sel[0] ? AW'(TRAIN_SYMS - 1) : AW'(DEPTH - 1);
  assign seed_ld   = go && (st == ST_SEED);
  assign prbs_adv  = go && (st == ST_RUN) && src_sel[1];
  assign sum       = {1'b0, err_count} + (CNT_W+1)'(nerr);

  sec_pattern_buf #(.SYM_W(SYM_W), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .we    (pb_we),
    .waddr (pb_addr),
    .wdata (pb_wdata),
    .raddr (rd_addr),
    .rdata (buf_word)
  );

  sec_prbs7 #(.SYM_W(SYM_W)) u_prbs (
    .clk     (clk),
    .rst     (rst || clr),
    .load    (seed_ld),
    .seed    (sym_data),
    .adv     (prbs_adv),
    .exp_sym (prbs_word)
  );

  sec_mask_count #(.SYM_W(SYM_W)) u_cnt (
    .rx       (sym_data),
    .ref_sym  (run_ref),
    .mask_sel (mask_sel),
    .nerr     (nerr)
  );

  // Configuration history tracks the inputs even during reset.
  always_ff @(posedge clk) begin
    mask_q <= mask_sel;
    src_q  <= src_sel;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st        <= ST_TRAIN;
      mcnt      <= '0;
      rptr      <= '0;
      locked    <= 1'b0;
      err_count <= '0;
    end else if (cfg_chg) begin
      st     <= ST_TRAIN;
      mcnt   <= '0;
      locked <= 1'b0;
    end else if (sym_valid) begin
      unique case (st)
        ST_TRAIN: begin
          if (sym_data == train_ref) begin
            if (mcnt == TW'(TRAIN_SYMS - 1)) begin
              mcnt   <= '0;
              rptr   <= '0;
              locked <= 1'b1;
              st     <= src_sel[1] ? ST_SEED : ST_RUN;
            end else begin
              mcnt <= mcnt + 1'b1;
            end
          end else begin
            mcnt <= '0;
          end
        end
        ST_SEED: st <= ST_RUN;
        ST_RUN: begin
          err_count <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
          rptr      <= (rptr == rptr_last) ? '0 : rptr + 1'b1;
        end
        default: st <= ST_TRAIN;
      endcase
    end
  end
endmodule

// File: rtl/sec_checker.sv
module sec_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             sym_valid,
  input logic [1:0]       mask_sel,
  input logic [1:0]       src_sel,
  input logic [CNT_W-1:0] err_count,
  input logic             locked
);
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (err_count == '0 && !locked));

  assert_lock_needs_symbol_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(sym_valid));

  assert_hold_unlocked_R4: assert property (@(posedge clk) disable iff (rst)
    (!locked && !clr) |=> $stable(err_count));

  assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (err_count - $past(err_count)) <= CNT_W'(10));

  assert_reserved_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (mask_sel == 2'b11 && !clr) |=> $stable(err_count));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    !clr |=> err_count >= $past(err_count));

  assert_relock_R12: assert property (@(posedge clk) disable iff (rst)
    (mask_sel != $past(mask_sel) || src_sel != $past(src_sel)) |=> !locked);
endmodule

bind sym_err_checker sec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .sym_valid (sym_valid),
  .mask_sel  (mask_sel),
  .src_sel   (src_sel),
  .err_count (err_count),
  .locked    (locked)
);

// File: tb/sym_err_checker_test.sv
module sym_err_checker_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       sym_valid = 1'b0;
  logic [9:0] sym_data = '0;
  logic [1:0] mask_sel = 2'b00;
  logic [1:0] src_sel = 2'b00;
  logic       pb_we = 1'b0;
  logic [2:0] pb_addr = '0;
  logic [9:0] pb_wdata = '0;
  logic [15:0] err_count;
  logic        locked;

  int n_run = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  logic pb [0:255];

  localparam logic [9:0] DEF = 10'h155;

  always #5 clk = ~clk;

  sym_err_checker uut (
    .clk(clk), .rst(rst), .clr(clr), .sym_valid(sym_valid), .sym_data(sym_data),
    .mask_sel(mask_sel), .src_sel(src_sel), .pb_we(pb_we), .pb_addr(pb_addr),
    .pb_wdata(pb_wdata), .err_count(err_count), .locked(locked)
  );

  function automatic logic [9:0] word(int i);
    return 10'((i * 173 + 91) % 1024);
  endfunction

  function automatic logic [9:0] errpat(int k);
    case (k % 6)
      0: return 10'h000;
      1: return 10'h3FF;
      2: return 10'h155;
      3: return 10'h2AA;
      4: return 10'h001;
      default: return 10'((k * 77) % 1024);
    endcase
  endfunction

  function automatic int mpop(logic [9:0] rx, logic [9:0] ex, logic [1:0] m);
    int c = 0;
    for (int i = 0; i < 10; i++)
      if (rx[i] != ex[i] && (m == 2'b00 || (m == 2'b01 && i % 2 == 1) || (m == 2'b10 && i % 2 == 0)))
        c++;
    return c;
  endfunction

  task automatic check(string req, int act, int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic send(logic [9:0] d);
    sym_valid = 1'b1;
    sym_data  = d;
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic set_cfg(logic [1:0] m, logic [1:0] s);
    mask_sel = m;
    src_sel  = s;
    @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    exp_cnt = 0;
  endtask

  task automatic add(int n);
    exp_cnt = exp_cnt + n;
    if (exp_cnt > 65535) exp_cnt = 65535;
  endtask

  task automatic train_def();
    for (int i = 0; i < 4; i++) send(DEF);
  endtask

  task automatic build_prbs(logic [9:0] seed);
    for (int j = 0; j < 10; j++) pb[j] = seed[j];
    for (int n = 10; n < 256; n++) pb[n] = pb[n-7] ^ pb[n-6];
  endtask

  function automatic logic [9:0] prbs_sym(int m);
    logic [9:0] r;
    for (int j = 0; j < 10; j++) r[j] = pb[10*m + j];
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [9:0] s;
    repeat (3) @(negedge clk);
    check("R1 reset count", int'(err_count), 0);
    check("R1 reset lock", int'(locked), 0);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      pb_we = 1'b1; pb_addr = 3'(i); pb_wdata = word(i);
      @(negedge clk);
    end
    pb_we = 1'b0;

    // R2: default training, broken run, idle cycles inside run
    for (int i = 0; i < 3; i++) send(DEF);
    send(word(0));
    check("R2 mismatch restarts", int'(locked), 0);
    for (int i = 0; i < 3; i++) send(DEF);
    check("R2 three matches", int'(locked), 0);
    repeat (2) @(negedge clk);
    send(DEF);
    check("R2 lock after fourth", int'(locked), 1);
    check("R4 no count before lock", int'(err_count), 0);

    // R5 / R9: full buffer reference, all bits
    for (int k = 0; k < 16; k++) begin
      s = word(k % 8) ^ errpat(k);
      send(s);
      add(mpop(s, word(k % 8), 2'b00));
      check("R5 R9 all-bit count", int'(err_count), exp_cnt);
    end

    // R6 R7 R8 with R12 relock on each change
    for (int m = 1; m < 4; m++) begin
      set_cfg(2'(m), 2'b00);
      check("R12 relock", int'(locked), 0);
      check("R12 count kept", int'(err_count), exp_cnt);
      s = 10'h3FF;
      send(s);
      check("R4 ignored while training", int'(err_count), exp_cnt);
      train_def();
      check("R2 relocked", int'(locked), 1);
      for (int k = 0; k < 8; k++) begin
        s = word(k) ^ errpat(k + m);
        send(s);
        add(mpop(s, word(k), 2'(m)));
        if (m == 1) check("R6 odd mask", int'(err_count), exp_cnt);
        else if (m == 2) check("R7 even mask", int'(err_count), exp_cnt);
        else check("R8 reserved mask", int'(err_count), exp_cnt);
      end
    end

    do_clear();
    check("R1 clear count", int'(err_count), 0);
    check("R1 clear lock", int'(locked), 0);

    // R3: first 40 bits training, must start at word 0
    set_cfg(2'b00, 2'b01);
    send(word(1)); send(word(2)); send(word(3));
    send(word(0)); send(word(1)); send(word(2));
    check("R3 not yet locked", int'(locked), 0);
    send(word(3));
    check("R3 locked on word 3", int'(locked), 1);
    for (int k = 0; k < 8; k++) begin
      s = word(k % 4) ^ errpat(k + 2);
      send(s);
      add(mpop(s, word(k % 4), 2'b00));
      check("R9 four-word cycle", int'(err_count), exp_cnt);
    end

    // R10: PRBS with default training
    set_cfg(2'b00, 2'b10);
    train_def();
    check("R10 locked", int'(locked), 1);
    build_prbs(10'h2C7);
    send(prbs_sym(0));
    check("R10 seed not counted", int'(err_count), exp_cnt);
    for (int m = 1; m < 13; m++) begin
      s = prbs_sym(m) ^ errpat(m);
      send(s);
      add(mpop(s, prbs_sym(m), 2'b00));
      check("R10 prbs compare", int'(err_count), exp_cnt);
    end

    // R10 with buffer training (src 11), odd mask
    set_cfg(2'b01, 2'b11);
    for (int i = 0; i < 4; i++) send(word(i));
    check("R3 R10 locked", int'(locked), 1);
    build_prbs(10'h1B3);
    send(prbs_sym(0));
    for (int m = 1; m < 7; m++) begin
      s = prbs_sym(m) ^ errpat(m + 1);
      send(s);
      add(mpop(s, prbs_sym(m), 2'b01));
      check("R10 prbs odd", int'(err_count), exp_cnt);
    end

    // R11: saturation
    do_clear();
    set_cfg(2'b00, 2'b00);
    train_def();
    for (int k = 0; k < 6600; k++) begin
      send(~word(k % 8));
      add(10);
      if (k == 6552) check("R11 below max", int'(err_count), exp_cnt);
    end
    check("R11 saturated", int'(err_count), 65535);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule